// File: doc/BRIEF.md
# Multi-Polynomial CRC and Checksum Engine

This block is a host-programmed integrity engine. Software picks an operation (one of four CRC polynomials, or a 16-bit ones'-complement checksum of the kind used by TCP), a start value policy and an input byte ordering. It then writes 32-bit words into a data register. Every data write folds the whole word into a running value in a single clock cycle, and the result register always shows the value for the words written so far.

The start value is chosen by a two-bit init code that stays pending until the next data write. At that write the engine loads the start value (the seed register, all zeros or all ones) and processes the word from it. The code then reads back as 00. The arming logic is a two-state machine. `ST_IDLE` means no start value is pending. `ST_ARMED` means one is. Transition `T_ARM` (any control write) enters `ST_ARMED` from either state. Transition `T_CONSUME` (a data write while armed) returns to `ST_IDLE`. A data write while idle stays in `ST_IDLE` (`T_STAY`).

The register file has four word addresses: control at 0, seed at 1, data at 2 (write-only, reads 0) and result at 3. Reads are combinational from the address.

Top module: `crcx_engine`

## Requirements
- R1: After reset the control register reads 0 and the result register reads 0.
- R2: The control register holds the operation code in bits 3:0, the swap control in bits 5:4 and the init code in bits 14:13. Every other bit reads 0.
- R3: Operation 0000 uses the 16-bit polynomial 0x8005, 0001 uses the 16-bit polynomial 0x1021, 0010 uses the 32-bit polynomial 0x04C11DB7 and 0011 uses the 32-bit polynomial 0x1EDC6F41. The 32 input bits are shifted in most significant bit first, with no reflection and no final XOR, and the whole word is processed in the cycle of the write. The running value changes only on data writes.
- R4: The 16-bit CRC operations and the checksum work on the low 16 bits only. The seed is truncated to 16 bits, and bits 31:16 of the result read 0.
- R5: Operation 1000 adds the upper and lower half-words of each word to a 16-bit running sum with end-around carry. The result register returns the ones' complement of that sum.
- R6: Init code 00 loads the seed, 10 loads zeros and 11 loads ones. The load happens at the first data write after a control write, before that word is processed.
- R7: The init field reads 00 after the first data write following a control write. Later data writes continue from the running value.
- R8: Swap bit 0 (control bit 4) exchanges the bytes inside each half-word. Swap bit 1 (control bit 5) exchanges the two half-words. Both swaps apply when both bits are set.
- R9: An operation code other than 0000, 0001, 0010, 0011 and 1000 leaves the running value unchanged by data, and the result reads the full 32-bit running value.
- R10: Init code 01 loads nothing. The running value carries over into the next data write.
- R11: The seed register reads back the last 32-bit value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 2 | Word address: 0 control, 1 seed, 2 data, 3 result |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register |

## Verification
The single-bit and shifted-bit vectors have results that can be worked out by hand. They expose a polynomial swapped between operation codes, a bit order reversed to LSB-first, or a 16-bit type shifting through 32 bits. Each swap mode is given a word that lands on the same value only when it is swapped correctly, so a misplaced byte or half-word swap produces a different CRC. In the checksum cases a half-word sum overflows 16 bits, which catches a dropped end-around carry, and a missing final complement shows up as an inverted result. Multi-word streams after a control write, together with an init code 01 write, show whether the start value is reloaded too often, never cleared, or applied after the word rather than before it.

// File: rtl/crcx_pkg.sv
package crcx_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_SEED = 2'd1;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd2;
    localparam logic [ADDR_W-1:0] A_RES  = 2'd3;

    localparam logic [3:0] OP_C16A = 4'b0000;
    localparam logic [3:0] OP_C16B = 4'b0001;
    localparam logic [3:0] OP_C32A = 4'b0010;
    localparam logic [3:0] OP_C32B = 4'b0011;
    localparam logic [3:0] OP_SUM  = 4'b1000;

    localparam logic [1:0] IN_SEED  = 2'b00;
    localparam logic [1:0] IN_NONE  = 2'b01;
    localparam logic [1:0] IN_ZERO  = 2'b10;
    localparam logic [1:0] IN_ONES  = 2'b11;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } arm_e;

    function automatic logic op_is_crc(input logic [3:0] op);
        return op[3:2] == 2'b00;
    endfunction

    function automatic logic op_is_narrow(input logic [3:0] op);
        return (op == OP_C16A) || (op == OP_C16B) || (op == OP_SUM);
    endfunction

    function automatic logic op_is_reserved(input logic [3:0] op);
        return !op_is_crc(op) && (op != OP_SUM);
    endfunction

endpackage

// File: rtl/crcx_swap.sv
module crcx_swap #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] din,
    input  logic [1:0]        mode,
    output logic [WORD_W-1:0] dout
);
    localparam int HALF_W = WORD_W / 2;
    localparam int BYTE_W = 8;
    localparam int NBYTE  = WORD_W / BYTE_W;

    logic [WORD_W-1:0] byte_sw;

    for (genvar b = 0; b < NBYTE; b += 2) begin : g_pair
        assign byte_sw[b*BYTE_W +: BYTE_W]     = mode[0] ? din[(b+1)*BYTE_W +: BYTE_W] : din[b*BYTE_W +: BYTE_W];
        assign byte_sw[(b+1)*BYTE_W +: BYTE_W] = mode[0] ? din[b*BYTE_W +: BYTE_W]     : din[(b+1)*BYTE_W +: BYTE_W];
    end

    assign dout = mode[1] ? {byte_sw[HALF_W-1:0], byte_sw[WORD_W-1:HALF_W]} : byte_sw;

endmodule

// File: rtl/crcx_crc_step.sv
module crcx_crc_step #(
    parameter int          CRC_W  = 16,
    parameter logic [31:0] POLY   = 32'h0000_8005,
    parameter int          DATA_W = 32
) (
    input  logic [CRC_W-1:0]  cur,
    input  logic [DATA_W-1:0] din,
    output logic [CRC_W-1:0]  nxt
);
    localparam logic [CRC_W-1:0] TAPS = POLY[CRC_W-1:0];

    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = cur;
        fb  = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ din[i];
            acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? TAPS : '0);
        end
        nxt = acc;
    end

endmodule

// File: rtl/crcx_sum_step.sv
module crcx_sum_step #(
    parameter int HALF_W = 16
) (
    input  logic [HALF_W-1:0]   cur,
    input  logic [2*HALF_W-1:0] din,
    output logic [HALF_W-1:0]   nxt
);
    logic [HALF_W+1:0] raw;
    logic [HALF_W:0]   fold1;
    logic [HALF_W:0]   fold2;

    always_comb begin
        raw   = {2'b00, cur} + {2'b00, din[2*HALF_W-1:HALF_W]} + {2'b00, din[HALF_W-1:0]};
        fold1 = {1'b0, raw[HALF_W-1:0]} + {{(HALF_W-1){1'b0}}, raw[HALF_W+1:HALF_W]};
        fold2 = {1'b0, fold1[HALF_W-1:0]} + {{HALF_W{1'b0}}, fold1[HALF_W]};
        nxt   = fold2[HALF_W-1:0];
    end

endmodule

// File: rtl/crcx_engine.sv
module crcx_engine
    import crcx_pkg::*;
#(
    parameter int N_CRC = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata
);
    localparam logic [31:0] CRC_POLY [N_CRC] = '{32'h0000_8005, 32'h0000_1021,
                                                 32'h04C1_1DB7, 32'h1EDC_6F41};
    localparam int          CRC_WID  [N_CRC] = '{16, 16, 32, 32};
    localparam int          SEL_W    = $clog2(N_CRC);

    // control and data registers
    logic [3:0]        type_q;
    logic [1:0]        endian_q;
    logic [1:0]        init_q;
    logic [WORD_W-1:0] seed_q;
    logic [WORD_W-1:0] run_q;
    arm_e              state_q, state_d;

    logic              wr_ctrl, wr_seed, wr_data;
    logic              load_start, clear_init;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_seed = wr_en && (addr == A_SEED);
    assign wr_data = wr_en && (addr == A_DATA);

    // arming state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and decoded actions
    always_comb begin
        state_d    = state_q;
        load_start = 1'b0;
        clear_init = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_ctrl) state_d = ST_ARMED;           // T_ARM
            end
            ST_ARMED: begin
                if (wr_data) begin                           // T_CONSUME
                    state_d    = ST_IDLE;
                    load_start = (init_q != IN_NONE);
                    clear_init = 1'b1;
                end else if (wr_ctrl) begin
                    state_d = ST_ARMED;                      // T_ARM
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath: swap, start value, steps
    logic [WORD_W-1:0] word_sw;
    logic [WORD_W-1:0] init_val;
    logic [WORD_W-1:0] start_raw;
    logic [WORD_W-1:0] start_val;
    logic [WORD_W-1:0] crc_nxt [N_CRC];
    logic [HALF_W-1:0] sum_nxt;
    logic [WORD_W-1:0] run_d;

    crcx_swap #(.WORD_W(WORD_W)) u_swap (
        .din  (wdata),
        .mode (endian_q),
        .dout (word_sw)
    );

    always_comb begin
        unique case (init_q)
            IN_ZERO: init_val = '0;
            IN_ONES: init_val = '1;
            default: init_val = seed_q;
        endcase
        start_raw = load_start ? init_val : run_q;
        start_val = op_is_narrow(type_q) ? {{(WORD_W-HALF_W){1'b0}}, start_raw[HALF_W-1:0]} : start_raw;
    end

    for (genvar g = 0; g < N_CRC; g++) begin : g_crc
        logic [CRC_WID[g]-1:0] step_out;
        crcx_crc_step #(
            .CRC_W  (CRC_WID[g]),
            .POLY   (CRC_POLY[g]),
            .DATA_W (WORD_W)
        ) u_step (
            .cur (start_val[CRC_WID[g]-1:0]),
            .din (word_sw),
            .nxt (step_out)
        );
        assign crc_nxt[g] = WORD_W'(step_out);
    end

    crcx_sum_step #(.HALF_W(HALF_W)) u_sum (
        .cur (start_val[HALF_W-1:0]),
        .din (word_sw),
        .nxt (sum_nxt)
    );

    always_comb begin
        if (op_is_crc(type_q))      run_d = crc_nxt[type_q[SEL_W-1:0]];
        else if (type_q == OP_SUM)  run_d = {{(WORD_W-HALF_W){1'b0}}, sum_nxt};
        else                        run_d = start_val;
    end

    // register updates
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            type_q   <= '0;
            endian_q <= '0;
            init_q   <= '0;
            seed_q   <= '0;
            run_q    <= '0;
        end else begin
            if (wr_ctrl) begin
                type_q   <= wdata[3:0];
                endian_q <= wdata[5:4];
                init_q   <= wdata[14:13];
            end else if (clear_init) begin
                init_q   <= IN_SEED;
            end
            if (wr_seed) seed_q <= wdata;
            if (wr_data) run_q  <= run_d;
        end
    end

    // read mux
    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = {17'b0, init_q, 7'b0, endian_q, type_q};
            A_SEED:  rdata = seed_q;
            A_DATA:  rdata = '0;
            default: begin
                if (type_q == OP_SUM)           rdata = {{(WORD_W-HALF_W){1'b0}}, ~run_q[HALF_W-1:0]};
                else if (op_is_narrow(type_q))  rdata = {{(WORD_W-HALF_W){1'b0}}, run_q[HALF_W-1:0]};
                else                            rdata = run_q;
            end
        endcase
    end

endmodule

// File: rtl/crcx_engine_chk.sv
module crcx_engine_chk
    import crcx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [WORD_W-1:0] rdata,
    input logic [3:0]        type_q,
    input logic [1:0]        init_q,
    input logic [WORD_W-1:0] run_q,
    input arm_e              state_q
);
    assert_run_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_DATA) |=> $stable(run_q));

    assert_init_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DATA) |=> (init_q == IN_SEED));

    assert_consume_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DATA) |=> (state_q == ST_IDLE));

    assert_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL) |=> (state_q == ST_ARMED));

    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_RES && op_is_narrow(type_q)) |-> (rdata[31:16] == 16'h0));

    assert_reserved_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DATA && state_q == ST_IDLE && op_is_reserved(type_q)) |=> $stable(run_q));

    assert_ctrl_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_CTRL) |-> (rdata[31:15] == 17'h0 && rdata[12:6] == 7'h0));
endmodule

bind crcx_engine crcx_engine_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .rdata   (rdata),
    .type_q  (type_q),
    .init_q  (init_q),
    .run_q   (run_q),
    .state_q (state_q)
);

// File: tb/crcx_engine_bench.sv
module crcx_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    crcx_engine u_crcx_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // bench-side model state
    logic [3:0]  m_type;
    logic [1:0]  m_end, m_init;
    logic [31:0] m_seed, m_run;
    bit          m_armed;

    function automatic logic [31:0] f_swap(input logic [31:0] d, input logic [1:0] e);
        logic [31:0] x;
        x = d;
        if (e[0]) x = {x[23:16], x[31:24], x[7:0], x[15:8]};
        if (e[1]) x = {x[15:0], x[31:16]};
        return x;
    endfunction

    function automatic logic [31:0] f_crc(input logic [31:0] c, input logic [31:0] d,
                                          input logic [31:0] poly, input int w);
        logic [31:0] x;
        logic        top;
        x = c;
        for (int i = 31; i >= 0; i--) begin
            top = ((w == 16) ? x[15] : x[31]) ^ d[i];
            x = (x << 1) ^ (top ? poly : 32'h0);
            if (w == 16) x = x & 32'h0000_FFFF;
        end
        return x;
    endfunction

    function automatic logic [15:0] f_sum(input logic [15:0] s, input logic [31:0] d);
        logic [31:0] t;
        t = {16'h0, s} + {16'h0, d[31:16]} + {16'h0, d[15:0]};
        while (t[31:16] != 0) t = {16'h0, t[15:0]} + {16'h0, t[31:16]};
        return t[15:0];
    endfunction

    function automatic logic [31:0] f_result();
        if (m_type == 4'b1000) return {16'h0, ~m_run[15:0]};
        if (m_type == 4'b0000 || m_type == 4'b0001) return {16'h0, m_run[15:0]};
        return m_run;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic w_ctrl(input logic [31:0] d);
        wr(2'd0, d);
        m_type = d[3:0]; m_end = d[5:4]; m_init = d[14:13]; m_armed = 1'b1;
    endtask

    task automatic w_seed(input logic [31:0] d);
        wr(2'd1, d);
        m_seed = d;
    endtask

    task automatic w_data(input logic [31:0] d);
        logic [31:0] st, sw;
        wr(2'd2, d);
        st = m_run;
        if (m_armed) begin
            if (m_init == 2'b00) st = m_seed;
            else if (m_init == 2'b10) st = 32'h0;
            else if (m_init == 2'b11) st = 32'hFFFF_FFFF;
            m_init = 2'b00; m_armed = 1'b0;
        end
        if (m_type == 4'b0000 || m_type == 4'b0001 || m_type == 4'b1000) st = st & 32'h0000_FFFF;
        sw = f_swap(d, m_end);
        case (m_type)
            4'b0000: m_run = f_crc(st, sw, 32'h0000_8005, 16);
            4'b0001: m_run = f_crc(st, sw, 32'h0000_1021, 16);
            4'b0010: m_run = f_crc(st, sw, 32'h04C1_1DB7, 32);
            4'b0011: m_run = f_crc(st, sw, 32'h1EDC_6F41, 32);
            4'b1000: m_run = {16'h0, f_sum(st[15:0], sw)};
            default: m_run = st;
        endcase
    endtask

    // {type[103:100], swap[99:98], init[97:96], seed[95:64], data[63:32], expected[31:0]}
    localparam int NV = 13;
    localparam logic [103:0] VEC [NV] = '{
        {4'h1, 2'b00, 2'b10, 32'h0,         32'h0000_0001, 32'h0000_1021},
        {4'h0, 2'b00, 2'b10, 32'h0,         32'h0000_0001, 32'h0000_8005},
        {4'h2, 2'b00, 2'b10, 32'h0,         32'h0000_0001, 32'h04C1_1DB7},
        {4'h3, 2'b00, 2'b10, 32'h0,         32'h0000_0001, 32'h1EDC_6F41},
        {4'h1, 2'b00, 2'b10, 32'h0,         32'h0000_0002, 32'h0000_2042},
        {4'h1, 2'b01, 2'b10, 32'h0,         32'h0000_0100, 32'h0000_1021},
        {4'h1, 2'b10, 2'b10, 32'h0,         32'h0001_0000, 32'h0000_1021},
        {4'h1, 2'b11, 2'b10, 32'h0,         32'h0100_0000, 32'h0000_1021},
        {4'h8, 2'b00, 2'b10, 32'h0,         32'h0001_0002, 32'h0000_FFFC},
        {4'h8, 2'b00, 2'b10, 32'h0,         32'hFFFF_0001, 32'h0000_FFFE},
        {4'h8, 2'b00, 2'b00, 32'hABCD_1234, 32'h0000_0000, 32'h0000_EDCB},
        {4'h4, 2'b00, 2'b00, 32'h1234_5678, 32'hDEAD_BEEF, 32'h1234_5678},
        {4'h8, 2'b00, 2'b11, 32'h0,         32'h0000_0000, 32'h0000_0000}
    };

    function automatic string vtag(input int i);
        case (i)
            0, 1, 2, 3, 4: return "R3";
            5, 6, 7:       return "R8";
            8, 9:          return "R5";
            10:            return "R4";
            11:            return "R9";
            default:       return "R6";
        endcase
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        m_type = 0; m_end = 0; m_init = 0; m_seed = 0; m_run = 0; m_armed = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(2'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(2'd3, v); chk("R1 result", v, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            w_ctrl({17'h0, VEC[i][97:96], 7'h0, VEC[i][99:98], VEC[i][103:100]});
            w_seed(VEC[i][95:64]);
            w_data(VEC[i][63:32]);
            rd(2'd3, v); chk(vtag(i), v, VEC[i][31:0]);
        end

        // R2 field layout, R7 self-clear of init
        w_ctrl(32'hFFFF_FFFF);
        rd(2'd0, v); chk("R2 ctrl layout", v, 32'h0000_603F);
        w_data(32'h1);
        rd(2'd0, v); chk("R7 init cleared", v, 32'h0000_003F);

        // R11 seed readback
        w_seed(32'hCAFE_F00D);
        rd(2'd1, v); chk("R11 seed", v, 32'hCAFE_F00D);

        // R10: code 01 keeps running sum 3, adding 1 gives ~4
        w_ctrl({17'h0, 2'b10, 7'h0, 2'b00, 4'h8});
        w_data(32'h0001_0002);
        w_ctrl({17'h0, 2'b01, 7'h0, 2'b00, 4'h8});
        w_data(32'h0000_0001);
        rd(2'd3, v); chk("R10 no init", v, 32'h0000_FFFB);

        // R4: 16-bit CRC seed truncation
        w_seed(32'hFFFF_0000);
        w_ctrl({17'h0, 2'b00, 7'h0, 2'b00, 4'h1});
        w_data(32'h0000_0001);
        rd(2'd3, v); chk("R4 seed trunc", v, 32'h0000_1021);

        // R7 multi-word CRC-32 stream continues
        w_ctrl({17'h0, 2'b11, 7'h0, 2'b00, 4'h2});
        w_data(32'h1234_5678);
        w_data(32'h9ABC_DEF0);
        rd(2'd0, v); chk("R7 init stays 00", v, 32'h0000_0002);
        w_data(32'h0F0F_F0F0);
        rd(2'd3, v); chk("R7 stream crc32", v, f_result());

        // R3 with R8 multi-word CRC-32C, full swap
        w_seed(32'h5A5A_A5A5);
        w_ctrl({17'h0, 2'b00, 7'h0, 2'b11, 4'h3});
        for (int k = 0; k < 4; k++) w_data(32'h0102_0304 * (k + 1));
        rd(2'd3, v); chk("R3 stream crc32c", v, f_result());

        // R4 upper half of 16-bit result stays zero
        w_ctrl({17'h0, 2'b11, 7'h0, 2'b00, 4'h0});
        w_data(32'hDEAD_BEEF);
        rd(2'd3, v); chk("R4 crc16 from ones", v, f_result());
        chk("R4 upper zero", {16'h0, v[31:16]}, 32'h0);

        // R9 reserved type after run: no change
        w_ctrl({17'h0, 2'b01, 7'h0, 2'b00, 4'hA});
        rd(2'd3, v); chk("R9 before", v, m_run);
        w_data(32'h7777_7777);
        rd(2'd3, v); chk("R9 reserved hold", v, m_run);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule